// File: doc/BRIEF.md
# Page-Splitting Serial Flash Program Engine

This block writes a byte range of any length and alignment into a serial NOR flash over a four-wire SPI link. A request supplies a start address and a byte count. The data bytes come in on a valid/ready stream. The engine cuts the range into program commands so that no command crosses a page boundary. The first command runs from the start address to the end of its page, or to the end of the range if that comes first. Each later command carries a full page, or whatever is left if that is less.

Before each command the engine polls the flash status register until the write-in-progress flag reads clear. It then sends a write-enable command in a frame of its own. After that it opens the program frame: the opcode, a 24-bit address, and then the data bytes. The address of each command is the start address plus the number of data bytes already sent. If the source stalls, the serial clock pauses and chip select stays low, so the command is never split. When the range is finished or rejected, the engine pulses `done` (with `error` when there is a fault) and holds the count of data bytes sent.

The controller steps through these states: IDLE, CHECK, POLL_CMD, POLL_READ, WREN_CMD, PROG_CMD, PROG_ADDR, PROG_DATA, SEP and FINISH. The transitions are:
- IDLE→CHECK when `start` is sampled.
- CHECK→FINISH for an empty or out-of-range request. Otherwise CHECK→POLL_CMD.
- POLL_CMD→POLL_READ when the status opcode has been sent.
- POLL_READ→SEP, with the resume target set as follows:
  - WREN_CMD when the flag reads idle.
  - POLL_CMD when the flag reads busy and the poll limit has not been reached.
  - FINISH, with the error flag set, when the flag reads busy on the last allowed poll.
- WREN_CMD→SEP, resuming at PROG_CMD.
- PROG_CMD→PROG_ADDR.
- PROG_ADDR→PROG_DATA after the third address byte.
- PROG_DATA→SEP after the last byte of the command. The resume target is FINISH if the range is complete, and POLL_CMD otherwise.
- SEP→the resume target, after one cycle with chip select high.
- FINISH→IDLE.

Top module: `flash_page_writer`

## Requirements
- R1: After reset these outputs are all low: `busy`, `done`, `error`, `spi_sck`, `src_ready` and `bytes_written`. `spi_cs_n` is high.
- R2: A request with a length of zero produces a `done` pulse with `error` low and `bytes_written` zero. It opens no SPI frame.
- R3: A request whose start address plus length exceeds `DEV_BYTES` produces a `done` pulse with `error` high and opens no SPI frame. A range that ends exactly at `DEV_BYTES` is accepted.
- R4: When the start offset within the page plus the length is at most `PAGE_BYTES`, the whole range goes out as a single program command.
- R5: Otherwise the first command carries `PAGE_BYTES` minus the start page offset, and each later command carries the smaller of `PAGE_BYTES` and the bytes remaining.
- R6: Every program command is preceded by one or more status-read frames and then a write-enable frame (one byte, 0x06). A status-read frame is two bytes: 0x05 and then the status byte read back. Polling repeats until bit 0 of the status byte (the write-in-progress flag) reads 0.
- R7: A program frame is the byte 0x02, then a 24-bit address sent most significant byte first, then the data bytes. Each byte is sent MSB first on `spi_mosi` in SPI mode 0. The address of each command equals the start address plus the data bytes already sent.
- R8: Chip select stays low from the opcode to the last byte of a frame and goes high between frames. `spi_sck` pulses only while chip select is low.
- R9: A source stall pauses `spi_sck` while chip select stays low, and the command is not split. `src_ready` is high only while `src_valid` is high and a frame is open.
- R10: `bytes_written` equals the number of data bytes sent, with opcode and address bytes excluded, and never exceeds the requested length.
- R11: If `POLL_LIMIT` consecutive status reads all return the flag set, the request ends with `done` and `error` high and no further frame.
- R12: A `start` pulse while `busy` is high is ignored. The request in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled in IDLE |
| start_addr | input | ADDR_W | First flash byte address |
| length | input | CNT_W | Number of bytes to write |
| src_data | input | 8 | Data byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_ready | output | 1 | Byte is taken this cycle |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Fault flag, valid with `done` |
| bytes_written | output | CNT_W | Data bytes sent for the last request |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the engine with a 16-byte page, a 1024-byte device, 12-bit counts and a poll limit of 8. With a page that small, ranges of a few dozen bytes produce three-command splits, runs that fill a page exactly, and both sides of the device-end boundary. A run with the flash stuck busy then reaches the poll-limit fault within a few hundred cycles. Addresses above 255 put a nonzero value in the middle address byte, which checks the byte order.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    localparam logic [7:0] CMD_STATUS    = 8'h05;
    localparam logic [7:0] CMD_WR_ENABLE = 8'h06;
    localparam logic [7:0] CMD_PROGRAM   = 8'h02;
    localparam logic [7:0] STAT_BUSY_MSK = 8'h01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_POLL_CMD,
        ST_POLL_READ,
        ST_WREN_CMD,
        ST_PROG_CMD,
        ST_PROG_ADDR,
        ST_PROG_DATA,
        ST_SEP,
        ST_FINISH
    } fpw_state_e;

endpackage

// File: rtl/fpw_byte_shifter.sv
// Mode-0 byte shifter: one clk per SCK half period, MSB first.
module fpw_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic       active_q;
    logic       phase_q;
    logic [2:0] bit_q;
    logic [7:0] sh_q;
    logic [7:0] rx_q;
    logic       done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    phase_q  <= 1'b0;
                    bit_q    <= '0;
                    sh_q     <= tx_byte;
                end
            end else if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                rx_q    <= {rx_q[6:0], miso};
                sh_q    <= {sh_q[6:0], 1'b0};
                if (bit_q == 3'd7) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    bit_q <= bit_q + 3'd1;
                end
            end
        end
    end

    assign sck     = active_q & phase_q;
    assign mosi    = sh_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;

    // R7
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active_q);

endmodule

// File: rtl/fpw_chunk_plan.sv
// Length of the next program command: up to the page end, capped by what is left.
module fpw_chunk_plan #(
    parameter int PAGE_BYTES = 256,
    parameter int CNT_W      = 25,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [CNT_W-1:0]  remain,
    output logic [PAGE_W:0]   chunk_len
);
    logic [PAGE_W:0] room;

    assign room = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, page_off};

    always_comb begin
        if (remain < CNT_W'(room)) begin
            chunk_len = (PAGE_W+1)'(remain);
        end else begin
            chunk_len = room;
        end
    end

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
    import fpw_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = ADDR_W + 1,
    parameter int PAGE_BYTES = 256,
    parameter int DEV_BYTES  = 1 << 24,
    parameter int POLL_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  length,
    input  logic [7:0]        src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [CNT_W-1:0]  bytes_written,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int SUM_W  = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    fpw_state_e state_q, state_d;
    fpw_state_e resume_q, resume_d;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  sent_q;
    logic [PAGE_W:0]   chunk_q;
    logic [POLL_W-1:0] poll_q;
    logic [1:0]        idx_q;
    logic              inflight_q;
    logic              err_q;

    logic              sh_go;
    logic [7:0]        sh_tx;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic              cs_n_c;
    logic              take_c;
    logic [PAGE_W:0]   plan_len;
    logic [SUM_W-1:0]  end_sum;
    logic              over_range;
    logic              flash_busy;
    logic              poll_last;
    logic              chunk_last;
    logic              range_last;
    logic [23:0]       frame_addr;

    assign end_sum    = SUM_W'(addr_q) + SUM_W'(len_q);
    assign over_range = end_sum > SUM_W'(DEV_BYTES);
    assign flash_busy = (sh_rx & STAT_BUSY_MSK) != 8'h00;
    assign poll_last  = poll_q == POLL_W'(POLL_LIMIT - 1);
    assign chunk_last = chunk_q == (PAGE_W+1)'(1);
    assign range_last = remain_q == CNT_W'(1);
    assign frame_addr = 24'(addr_q);

    fpw_byte_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    fpw_chunk_plan #(
        .PAGE_BYTES (PAGE_BYTES),
        .CNT_W      (CNT_W)
    ) u_plan (
        .page_off  (addr_q[PAGE_W-1:0]),
        .remain    (remain_q),
        .chunk_len (plan_len)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            resume_q <= ST_IDLE;
        end else begin
            state_q  <= state_d;
            resume_q <= resume_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        resume_d = resume_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (len_q == '0 || over_range) state_d = ST_FINISH;
                else                           state_d = ST_POLL_CMD;
            end
            ST_POLL_CMD: begin
                if (sh_done) state_d = ST_POLL_READ;
            end
            ST_POLL_READ: begin
                if (sh_done) begin
                    state_d = ST_SEP;
                    if (!flash_busy)    resume_d = ST_WREN_CMD;
                    else if (poll_last) resume_d = ST_FINISH;
                    else                resume_d = ST_POLL_CMD;
                end
            end
            ST_WREN_CMD: begin
                if (sh_done) begin
                    state_d  = ST_SEP;
                    resume_d = ST_PROG_CMD;
                end
            end
            ST_PROG_CMD: begin
                if (sh_done) state_d = ST_PROG_ADDR;
            end
            ST_PROG_ADDR: begin
                if (sh_done && idx_q == 2'd2) state_d = ST_PROG_DATA;
            end
            ST_PROG_DATA: begin
                if (sh_done && chunk_last) begin
                    state_d  = ST_SEP;
                    resume_d = range_last ? ST_FINISH : ST_POLL_CMD;
                end
            end
            ST_SEP: begin
                state_d = resume_q;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs towards the shifter, the bus and the source
    always_comb begin
        cs_n_c = 1'b1;
        sh_go  = 1'b0;
        sh_tx  = 8'h00;
        take_c = 1'b0;
        unique case (state_q)
            ST_POLL_CMD: begin
                cs_n_c = 1'b0;
                sh_tx  = CMD_STATUS;
                sh_go  = !inflight_q;
            end
            ST_POLL_READ: begin
                cs_n_c = 1'b0;
                sh_go  = !inflight_q;
            end
            ST_WREN_CMD: begin
                cs_n_c = 1'b0;
                sh_tx  = CMD_WR_ENABLE;
                sh_go  = !inflight_q;
            end
            ST_PROG_CMD: begin
                cs_n_c = 1'b0;
                sh_tx  = CMD_PROGRAM;
                sh_go  = !inflight_q;
            end
            ST_PROG_ADDR: begin
                cs_n_c = 1'b0;
                sh_go  = !inflight_q;
                case (idx_q)
                    2'd0:    sh_tx = frame_addr[23:16];
                    2'd1:    sh_tx = frame_addr[15:8];
                    default: sh_tx = frame_addr[7:0];
                endcase
            end
            ST_PROG_DATA: begin
                cs_n_c = 1'b0;
                sh_tx  = src_data;
                take_c = !inflight_q && src_valid;
                sh_go  = take_c;
            end
            default: begin
                cs_n_c = 1'b1;
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            len_q      <= '0;
            remain_q   <= '0;
            sent_q     <= '0;
            chunk_q    <= '0;
            poll_q     <= '0;
            idx_q      <= '0;
            inflight_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (sh_go)        inflight_q <= 1'b1;
            else if (sh_done) inflight_q <= 1'b0;

            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q   <= start_addr;
                        len_q    <= length;
                        remain_q <= length;
                        sent_q   <= '0;
                        poll_q   <= '0;
                        err_q    <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    if (len_q != '0 && over_range) err_q <= 1'b1;
                end
                ST_POLL_READ: begin
                    if (sh_done) begin
                        if (!flash_busy)    poll_q <= '0;
                        else if (poll_last) err_q  <= 1'b1;
                        else                poll_q <= poll_q + 1'b1;
                    end
                end
                ST_WREN_CMD: begin
                    if (sh_done) begin
                        chunk_q <= plan_len;
                        idx_q   <= '0;
                    end
                end
                ST_PROG_ADDR: begin
                    if (sh_done) idx_q <= idx_q + 2'd1;
                end
                ST_PROG_DATA: begin
                    if (sh_done) begin
                        chunk_q  <= chunk_q - 1'b1;
                        remain_q <= remain_q - 1'b1;
                        addr_q   <= addr_q + 1'b1;
                        sent_q   <= sent_q + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign spi_cs_n      = cs_n_c;
    assign src_ready     = take_c;
    assign busy          = state_q != ST_IDLE;
    assign done          = state_q == ST_FINISH;
    assign error         = (state_q == ST_FINISH) && err_q;
    assign bytes_written = sent_q;

    // R8
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    // R9
    src_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (src_valid && !spi_cs_n));

    // R5
    chunk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_DATA && sh_done && chunk_last)
            |-> ((&addr_q[PAGE_W-1:0]) || range_last));

    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q <= len_q);

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_flash_page_writer.sv
module tb_flash_page_writer;
    localparam int PAGE = 16;
    localparam int DEV  = 1024;
    localparam int LIM  = 8;
    localparam int AW   = 24;
    localparam int CW   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] length = '0;
    logic [7:0]    src_data = 8'h00;
    logic          src_valid = 1'b0;
    logic          src_ready, busy, done, error;
    logic [CW-1:0] bytes_written;
    logic          spi_sck, spi_cs_n, spi_mosi, spi_miso;

    flash_page_writer #(
        .ADDR_W(AW), .CNT_W(CW), .PAGE_BYTES(PAGE), .DEV_BYTES(DEV), .POLL_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .length(length), .src_data(src_data), .src_valid(src_valid),
        .src_ready(src_ready), .busy(busy), .done(done), .error(error),
        .bytes_written(bytes_written), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- data source ----------------
    int  src_idx = 0;
    bit  src_clr = 1'b0;
    bit  src_en  = 1'b0;
    bit  stall_mode = 1'b0;
    int  cyc = 0;
    int  seed = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + seed) & 255);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_clr) src_idx <= 0;
        else if (src_valid && src_ready) src_idx <= src_idx + 1;
    end

    always @(negedge clk) begin
        src_valid <= src_en && !(stall_mode && ((cyc % 7) < 4));
        src_data  <= pat(src_idx);
    end

    // stretch of SCK-low cycles with chip select held
    int low_run = 0;
    int max_low_run = 0;
    always @(negedge clk) begin
        if (!spi_cs_n && !spi_sck) begin
            low_run = low_run + 1;
            if (low_run > max_low_run) max_low_run = low_run;
        end else begin
            low_run = 0;
        end
    end

    // ---------------- flash model ----------------
    int         bit_n = 0;
    logic [7:0] shin = 8'h00;
    logic [7:0] fb [0:299];
    int         fbn = 0;
    int         busy_left = 0;
    int         busy_per_prog = 0;
    logic       wel = 1'b0;
    logic [7:0] mem [0:DEV-1];
    logic [7:0] resp = 8'h00;
    int         log_n = 0;
    int         log_op   [0:127];
    int         log_len  [0:127];
    int         log_addr [0:127];
    int         model_err = 0;

    assign spi_miso = resp[7];

    always @(negedge spi_cs_n) begin
        bit_n = 0;
        fbn   = 0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            shin  = {shin[6:0], spi_mosi};
            bit_n = bit_n + 1;
            if (bit_n % 8 == 0 && fbn < 300) begin
                fb[fbn] = shin;
                fbn = fbn + 1;
                if (fbn == 1 && shin == 8'h05)
                    resp = {6'b0, wel, (busy_left > 0)};
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && bit_n > 8) resp = {resp[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) begin
        if (fbn > 0) begin
            if (log_n < 128) begin
                log_op[log_n]   = int'(fb[0]);
                log_len[log_n]  = fbn;
                log_addr[log_n] = (fbn >= 4) ? int'({fb[1], fb[2], fb[3]}) : -1;
                log_n = log_n + 1;
            end
            if (bit_n % 8 != 0) model_err++;
            case (fb[0])
                8'h05: if (busy_left > 0) busy_left--;
                8'h06: wel = 1'b1;
                8'h02: begin
                    if (!wel || busy_left > 0 || fbn < 4) model_err++;
                    for (int i = 4; i < fbn; i++)
                        mem[(int'({fb[1], fb[2], fb[3]}) + i - 4) % DEV] = fb[i];
                    wel = 1'b0;
                    busy_left = busy_per_prog;
                end
                default: model_err++;
            endcase
        end
    end

    // ---------------- expected frame list ----------------
    int exp_n = 0;
    int exp_op   [0:127];
    int exp_len  [0:127];
    int exp_addr [0:127];

    task automatic plan_frames(input int a, input int n, input int b, input int ib);
        int off;
        int rem;
        int ln;
        bit first;
        exp_n = 0; off = a; rem = n; first = 1'b1;
        while (rem > 0 && exp_n < 120) begin
            for (int r = 0; r < (first ? ib + 1 : b + 1); r++) begin
                exp_op[exp_n] = 5; exp_len[exp_n] = 2; exp_addr[exp_n] = -1; exp_n++;
            end
            exp_op[exp_n] = 6; exp_len[exp_n] = 1; exp_addr[exp_n] = -1; exp_n++;
            ln = PAGE - (off % PAGE);
            if (rem < ln) ln = rem;
            exp_op[exp_n] = 2; exp_len[exp_n] = 4 + ln; exp_addr[exp_n] = off; exp_n++;
            off += ln; rem -= ln; first = 1'b0;
        end
    endtask

    task automatic cmp_frames(input string req);
        int bad;
        chk(log_n == exp_n, req, "frame count", log_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (bad < 0 && (log_op[i] != exp_op[i] || log_len[i] != exp_len[i] ||
                            (exp_op[i] == 2 && log_addr[i] != exp_addr[i]))) bad = i;
        end
        if (bad < 0) chk(1'b1, req, "frame sequence", 0, 0);
        else chk(1'b0, req, $sformatf("frame %0d op/len/addr %0d/%0d/%0d vs", bad,
                 log_op[bad], log_len[bad], log_addr[bad]), exp_len[bad], exp_addr[bad]);
        chk(model_err == 0, req, "flash model protocol errors", model_err, 0);
    endtask

    task automatic cmp_mem(input string req, input int a, input int n);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) if (mem[(a + i) % DEV] !== pat(i)) bad++;
        if (a > 0 && mem[a - 1] !== 8'hEE) bad++;
        if (a + n < DEV && mem[a + n] !== 8'hEE) bad++;
        chk(bad == 0, req, "flash contents mismatching bytes", bad, 0);
    endtask

    bit r_err;
    int r_bw;

    task automatic run_req(input int a, input int n, input int b, input int ib,
                           input bit stall, input int poke_at);
        int t;
        log_n = 0; model_err = 0; wel = 1'b0;
        busy_left = ib; busy_per_prog = b; stall_mode = stall;
        max_low_run = 0; seed = seed + 11;
        for (int i = 0; i < DEV; i++) mem[i] = 8'hEE;
        @(negedge clk); src_clr = 1'b1; src_en = 1'b1;
        @(negedge clk); src_clr = 1'b0;
        start = 1'b1; start_addr = AW'(a); length = CW'(n);
        @(negedge clk); start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (t == poke_at) begin
                start = 1'b1; start_addr = '0; length = CW'(5);
            end else begin
                start = 1'b0;
            end
        end
        chk(done == 1'b1, "R2", "done reached before timeout", done, 1);
        r_err = error;
        r_bw  = int'(bytes_written);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R2", "done is one cycle, back to idle",
            {done, busy}, 0);
        src_en = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(busy == 0 && done == 0 && error == 0, "R1", "busy/done/error", {busy, done, error}, 0);
        chk(spi_cs_n == 1 && spi_sck == 0, "R1", "cs_n/sck", {spi_cs_n, spi_sck}, 2);
        chk(src_ready == 0 && bytes_written == 0, "R1", "ready/count",
            int'(bytes_written) + src_ready, 0);
    endtask

    task automatic t_zero_len;
        run_req(5, 0, 0, 0, 1'b0, -1);
        chk(r_err == 0, "R2", "error on empty request", r_err, 0);
        chk(r_bw == 0, "R2", "bytes_written", r_bw, 0);
        chk(log_n == 0, "R2", "frames opened", log_n, 0);
    endtask

    task automatic t_range;
        run_req(1000, 25, 0, 0, 1'b0, -1);
        chk(r_err == 1, "R3", "error beyond device end", r_err, 1);
        chk(log_n == 0, "R3", "frames opened", log_n, 0);
        run_req(1000, 24, 1, 0, 1'b0, -1);
        chk(r_err == 0, "R3", "error at exact device end", r_err, 0);
        plan_frames(1000, 24, 1, 0);
        cmp_frames("R7");
        cmp_mem("R3", 1000, 24);
        chk(r_bw == 24, "R10", "bytes_written", r_bw, 24);
    endtask

    task automatic t_single;
        run_req(35, 10, 0, 1, 1'b0, -1);
        plan_frames(35, 10, 0, 1);
        cmp_frames("R4");
        cmp_mem("R4", 35, 10);
        chk(r_bw == 10 && r_err == 0, "R10", "bytes_written", r_bw, 10);
        chk(max_low_run <= 4, "R9", "sck gap without stall", max_low_run, 4);
        run_req(48, 16, 0, 0, 1'b0, -1);
        plan_frames(48, 16, 0, 0);
        cmp_frames("R4");
        cmp_mem("R4", 48, 16);
    endtask

    task automatic t_split;
        run_req(21, 40, 2, 0, 1'b0, -1);
        plan_frames(21, 40, 2, 0);
        cmp_frames("R5");
        cmp_frames("R6");
        cmp_mem("R5", 21, 40);
        chk(r_bw == 40 && r_err == 0, "R10", "bytes_written", r_bw, 40);
        run_req(300, 33, 0, 0, 1'b0, -1);
        plan_frames(300, 33, 0, 0);
        cmp_frames("R7");
        cmp_mem("R8", 300, 33);
    endtask

    task automatic t_stall;
        run_req(65, 20, 1, 0, 1'b1, -1);
        plan_frames(65, 20, 1, 0);
        cmp_frames("R9");
        cmp_mem("R9", 65, 20);
        chk(max_low_run >= 5, "R9", "sck paused with cs held", max_low_run, 5);
        chk(r_bw == 20, "R10", "bytes_written", r_bw, 20);
    endtask

    task automatic t_timeout;
        run_req(10, 4, 0, 1000000, 1'b0, -1);
        chk(r_err == 1, "R11", "error on stuck busy", r_err, 1);
        chk(r_bw == 0, "R11", "bytes_written", r_bw, 0);
        exp_n = 0;
        for (int i = 0; i < LIM; i++) begin
            exp_op[exp_n] = 5; exp_len[exp_n] = 2; exp_addr[exp_n] = -1; exp_n++;
        end
        cmp_frames("R11");
    endtask

    task automatic t_ignore_start;
        run_req(256, 20, 1, 0, 1'b0, 30);
        plan_frames(256, 20, 1, 0);
        cmp_frames("R12");
        cmp_mem("R12", 256, 20);
        chk(r_bw == 20 && r_err == 0, "R12", "bytes_written", r_bw, 20);
    endtask

    initial begin : watchdog
        #(8 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_len();
        t_range();
        t_single();
        t_split();
        t_stall();
        t_timeout();
        t_ignore_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule